// File: doc/BRIEF.md
# Clock Divisor Control Register

This block is a 16-bit control register on a simple synchronous register bus. It holds the clock division settings of a clock unit. The bus has an already address-decoded write strobe, write data, and read data that always shows the register. Two of the fields are decoded into plain divide ratios: one for the internal RC oscillator postscaler and one for the PLL output postscaler. A prescaler field is only stored and read back.

The register also drives a doze generator. The generator runs on the free-running peripheral clock and produces a processor clock-enable. When doze is off, the enable stays high on every cycle, so the ratio is 1:1. When doze is on, the enable pulses for one cycle out of every N, where N is 2 to the power of the doze ratio field.

Doze enable and the doze ratio field lock each other, so some writes are dropped without any notice. An optional recover-on-interrupt bit clears doze enable in hardware when an interrupt event arrives.

The generator is a two-state machine. In FULL, the enable follows the restart flag only. In DOZE, the enable fires when the cycle counter reaches N-1. The machine moves between FULL and DOZE whenever the active ratio changes. A change of active ratio is the RESTART transition: for that one cycle the enable is held low, and the counter is reloaded to zero.

Top module: `clkdiv_ctl`

## Requirements
- R1: After reset, the read data is 0x3040, the RC ratio output is 1, the PLL ratio output is 4, and the clock-enable is high.
- R2: The read data layout is as follows. Bit 15 is recover-on-interrupt. Bits 14:12 are the doze ratio code. Bit 11 is doze enable. Bits 10:8 are the RC postscaler code. Bits 7:6 are the PLL postscaler code. Bits 4:0 are the prescaler. A write is visible on the read data in the cycle after the write strobe.
- R3: While doze enable is 1, a write leaves bits 14:12 unchanged, and all other writable fields of that write still update.
- R4: A write with bit 11 set leaves doze enable at 0 if the doze ratio code is 000 after that same write.
- R5: With recover-on-interrupt at 1, an interrupt event clears doze enable on the next cycle. With it at 0, an interrupt event leaves doze enable unchanged.
- R6: When an interrupt-driven clear and a write that sets doze enable happen in the same cycle, doze enable ends at 0. The other fields of that write are still stored.
- R7: RC code k gives a ratio output of 2^k for k from 0 to 6, and code 7 gives 256.
- R8: PLL codes 00, 01 and 11 give ratio outputs 2, 4 and 8. The reserved code 10 reads back as 10 and gives 4.
- R9: With doze enable at 0, the clock-enable is high on every cycle, except one low cycle right after the active ratio changes.
- R10: With doze enable at 1 and ratio code k, let cycle 0 be the cycle in which the new setting first shows on the read data. The clock-enable is then high exactly on cycles N, 2N, and so on, where N = 2^k, and it is never high for two cycles in a row.
- R11: Bit 5 always reads 0, whatever value is written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Address-decoded write strobe |
| reg_wdata | input | 16 | Write data |
| irq_evt | input | 1 | Interrupt event, one bit per cycle |
| reg_rdata | output | 16 | Register read data |
| rc_div_ratio | output | 9 | Decoded RC postscaler divide value |
| pll_div_ratio | output | 4 | Decoded PLL postscaler divide value |
| cpu_clk_en | output | 1 | Processor clock-enable pulse |

## Verification
A software write that sets doze enable and an interrupt-driven clear can land in the same cycle. The bench provokes this by raising the write strobe and the interrupt event on the same clock edge while recover-on-interrupt is already 1. It then checks on the read data that doze enable is 0 and that the rest of the written word was stored.

A second collision is between a register update and a pulse of the doze counter. Each change of doze setting is therefore followed by a cycle-indexed scan of the clock-enable, counted from the cycle in which the new value is visible.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int REG_W     = 16;
    localparam int SEL_W     = 3;
    localparam int PLL_W     = 2;
    localparam int PRE_W     = 5;
    localparam int RC_OUT_W  = (1 << SEL_W) + 1;
    localparam int PLL_OUT_W = 4;

    typedef struct packed {
        logic             roi;
        logic [SEL_W-1:0] doze_sel;
        logic             doze_on;
        logic [SEL_W-1:0] rc_sel;
        logic [PLL_W-1:0] pll_sel;
        logic [PRE_W-1:0] pre;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{roi: 1'b0, doze_sel: 3'd3, doze_on: 1'b0,
                                   rc_sel: 3'd0, pll_sel: 2'b01, pre: 5'd0};

    typedef enum logic {
        MODE_FULL,
        MODE_DOZE
    } doze_mode_e;

    function automatic logic [REG_W-1:0] pack_read(input ctl_t c);
        return {c.roi, c.doze_sel, c.doze_on, c.rc_sel, c.pll_sel, 1'b0, c.pre};
    endfunction
endpackage

// File: rtl/clkdiv_regfile.sv
module clkdiv_regfile
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_evt,
    output ctl_t             ctl_q,
    output logic [REG_W-1:0] rd_data
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.roi = wr_data[15];
            if (!ctl_q.doze_on) begin
                ctl_d.doze_sel = wr_data[14:12];
            end
            ctl_d.doze_on = wr_data[11] && (ctl_d.doze_sel != '0);
            ctl_d.rc_sel  = wr_data[10:8];
            ctl_d.pll_sel = wr_data[7:6];
            ctl_d.pre     = wr_data[4:0];
        end
        if (ctl_q.roi && irq_evt) begin
            ctl_d.doze_on = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_data = pack_read(ctl_q);

    // R3
    ratio_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.doze_on |=> (ctl_q.doze_sel == $past(ctl_q.doze_sel)));

    // R4
    doze_needs_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.doze_on |-> (ctl_q.doze_sel != '0));

    // R5
    irq_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.roi && irq_evt) |=> !ctl_q.doze_on);
endmodule

// File: rtl/clkdiv_ratio_decode.sv
module clkdiv_ratio_decode
    import clkdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     rc_sel,
    input  logic [PLL_W-1:0]     pll_sel,
    output logic [RC_OUT_W-1:0]  rc_ratio,
    output logic [PLL_OUT_W-1:0] pll_ratio
);
    localparam int RC_TOP = (1 << SEL_W) - 1;

    always_comb begin
        if (int'(rc_sel) == RC_TOP) begin
            rc_ratio = RC_OUT_W'(1) << RC_TOP + 1;
        end else begin
            rc_ratio = RC_OUT_W'(1) << rc_sel;
        end
    end

    always_comb begin
        unique case (pll_sel)
            2'b00:   pll_ratio = PLL_OUT_W'(2);
            2'b11:   pll_ratio = PLL_OUT_W'(8);
            default: pll_ratio = PLL_OUT_W'(4);
        endcase
    end

    // R7
    rc_power_of_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rc_ratio) == 1);

    // R8
    pll_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pll_ratio) == 1) && !pll_ratio[0]);
endmodule

// File: rtl/clkdiv_doze_gen.sv
module clkdiv_doze_gen
    import clkdiv_pkg::*;
#(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               doze_on,
    input  logic [SHIFT_W-1:0] doze_sel,
    output logic               cpu_clk_en
);
    localparam int CNT_W = (1 << SHIFT_W) - 1;

    doze_mode_e         mode_q;
    doze_mode_e         mode_d;
    logic [SHIFT_W-1:0] shift_now;
    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim;
    logic [CNT_W:0]     span;
    logic               restart;

    assign shift_now = doze_on ? doze_sel : '0;
    assign restart   = (shift_now != shift_q);
    assign span      = (CNT_W + 1)'(1) << shift_q;
    assign lim       = CNT_W'(span - 1'b1);
    assign mode_d    = (shift_now == '0) ? MODE_FULL : MODE_DOZE;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_FULL;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            mode_q  <= mode_d;
            shift_q <= shift_now;
            if (restart || (cnt_q == lim)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (mode_q)
            MODE_FULL: cpu_clk_en = !restart;
            MODE_DOZE: cpu_clk_en = !restart && (cnt_q == lim);
            default:   cpu_clk_en = 1'b0;
        endcase
    end

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DOZE && cpu_clk_en) |=> !cpu_clk_en);

    // R10
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_ctl.sv
module clkdiv_ctl
    import clkdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 irq_evt,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [RC_OUT_W-1:0]  rc_div_ratio,
    output logic [PLL_OUT_W-1:0] pll_div_ratio,
    output logic                 cpu_clk_en
);
    ctl_t ctl;

    clkdiv_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_data (reg_wdata),
        .irq_evt (irq_evt),
        .ctl_q   (ctl),
        .rd_data (reg_rdata)
    );

    clkdiv_ratio_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_sel    (ctl.rc_sel),
        .pll_sel   (ctl.pll_sel),
        .rc_ratio  (rc_div_ratio),
        .pll_ratio (pll_div_ratio)
    );

    clkdiv_doze_gen #(.SHIFT_W(SEL_W)) u_doze (
        .clk        (clk),
        .rst_n      (rst_n),
        .doze_on    (ctl.doze_on),
        .doze_sel   (ctl.doze_sel),
        .cpu_clk_en (cpu_clk_en)
    );

    // R11
    bit5_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[5]) |=> !reg_rdata[5]);
endmodule

// File: tb/test_clkdiv_ctl.sv
module test_clkdiv_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        irq_evt = 1'b0;
    logic [15:0] reg_rdata;
    logic [8:0]  rc_div_ratio;
    logic [3:0]  pll_div_ratio;
    logic        cpu_clk_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkdiv_ctl i_clkdiv_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_wdata     (reg_wdata),
        .irq_evt       (irq_evt),
        .reg_rdata     (reg_rdata),
        .rc_div_ratio  (rc_div_ratio),
        .pll_div_ratio (pll_div_ratio),
        .cpu_clk_en    (cpu_clk_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic irq_pulse();
        @(negedge clk);
        irq_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0;
    endtask

    task automatic scan_pulses(input int n, input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            chk(req, {31'd0, cpu_clk_en}, {31'd0, (i > 0) && (i % n == 0)});
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 rdata", {16'd0, reg_rdata}, 32'h3040);
        chk("R1 rc", {23'd0, rc_div_ratio}, 32'd1);
        chk("R1 pll", {28'd0, pll_div_ratio}, 32'd4);
        chk("R1 en", {31'd0, cpu_clk_en}, 32'd1);
    endtask

    task automatic t_lock();
        wr(16'h1840);
        chk("R2 layout", {16'd0, reg_rdata}, 32'h1840);
        wr(16'h5B7F);
        chk("R3 ratio held, R11 bit5", {16'd0, reg_rdata}, 32'h1B5F);
        chk("R3 rc updated", {23'd0, rc_div_ratio}, 32'd8);
    endtask

    task automatic t_zero_ratio();
        wr(16'h0000);
        chk("R3 clear keeps ratio", {16'd0, reg_rdata}, 32'h1000);
        wr(16'h0800);
        chk("R4 enable ignored", {16'd0, reg_rdata}, 32'h0000);
        wr(16'h2800);
        chk("R4 enable accepted", {16'd0, reg_rdata}, 32'h2800);
    endtask

    task automatic t_irq();
        wr(16'h0000);
        chk("R5 setup", {16'd0, reg_rdata}, 32'h2000);
        wr(16'hB840);
        chk("R5 armed", {16'd0, reg_rdata}, 32'hB840);
        irq_pulse();
        chk("R5 recover", {16'd0, reg_rdata}, 32'hB040);
        wr(16'h3840);
        irq_pulse();
        chk("R5 no recover", {16'd0, reg_rdata}, 32'h3840);
        wr(16'hB840);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = 16'hB8DF;
        irq_evt = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        irq_evt = 1'b0;
        chk("R6 clear wins", {16'd0, reg_rdata}, 32'hB0DF);
    endtask

    task automatic t_pll();
        wr(16'h0000);
        chk("R8 code00", {28'd0, pll_div_ratio}, 32'd2);
        wr(16'h0080);
        chk("R8 reserved stored", {16'd0, reg_rdata}, 32'h0080);
        chk("R8 reserved ratio", {28'd0, pll_div_ratio}, 32'd4);
        wr(16'h00C0);
        chk("R8 code11", {28'd0, pll_div_ratio}, 32'd8);
        wr(16'h0040);
        chk("R8 code01", {28'd0, pll_div_ratio}, 32'd4);
    endtask

    task automatic t_rc();
        for (int k = 0; k < 8; k++) begin
            wr(16'(k << 8));
            chk("R7 rc", {23'd0, rc_div_ratio}, (k == 7) ? 32'd256 : (32'd1 << k));
        end
    endtask

    task automatic t_full();
        wr(16'h3040);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk("R9 full rate", {31'd0, cpu_clk_en}, 32'd1);
            @(negedge clk);
        end
    endtask

    task automatic t_doze();
        wr(16'h3840);
        scan_pulses(8, 40, "R10 div8");
        wr(16'h3040);
        wr(16'h1840);
        scan_pulses(2, 20, "R10 div2");
        wr(16'h1040);
        wr(16'h7840);
        scan_pulses(128, 300, "R10 div128");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_zero_ratio();
        t_irq();
        t_pll();
        t_rc();
        t_full();
        t_doze();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule